// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit carries out the four single-bit operations of a processor datapath: a plain test, test-then-set, test-then-invert and test-then-clear. It takes a 32-bit operand, a bit number and an operation code. The bit number may come from an immediate or from a register. A mode input tells the unit whether the operand is a full data register or a byte fetched from memory.

The unit returns three things: the modified operand, a write-back enable, and the new zero flag with its update enable. The zero flag reflects the addressed bit as it stood before any change. No other condition flag is produced, so the flags outside Z are left as they were.

A valid strobe on the input produces one registered result on the following cycle. Fetching the operand and writing memory are done by the surrounding datapath.

Top module: `bitop_unit`

## Requirements
- R1: While reset is held, and after it until the first strobe, out_valid, out_wr_en, out_z_en, out_z and out_data are all zero.
- R2: Each cycle with in_valid high produces exactly one cycle of out_valid on the next clock edge. out_valid is low after any cycle without a strobe.
- R3: out_z is 1 when the addressed bit of in_data was 0, and 0 when it was 1. It is always taken from the bit before modification.
- R4: Operation code 1 (set) drives the addressed bit of out_data to 1.
- R5: Operation code 3 (clear) drives the addressed bit of out_data to 0.
- R6: Operation code 2 (change) drives the addressed bit of out_data to the inverse of its input value.
- R7: Operation code 0 (test) keeps out_wr_en low and returns in_data unchanged on out_data.
- R8: With in_mem low (register operand), the addressed bit is in_bitno modulo 32.
- R9: With in_mem high (memory byte), the addressed bit is in_bitno modulo 8. Bits 31:8 of out_data then equal those of in_data.
- R10: Every bit of out_data other than the addressed one equals the same bit of in_data.
- R11: out_wr_en is high exactly on result cycles of codes 1, 2 and 3. out_z_en is high on every result cycle and on no other cycle.
- R12: A cycle without a strobe leaves out_data and out_z holding their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | 0 test, 1 set, 2 change, 3 clear |
| in_mem | input | 1 | 1: memory byte operand, 0: register operand |
| in_bitno | input | BITNO_W (6) | Bit number, before wrapping |
| in_data | input | REG_W (32) | Operand value |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_data | output | REG_W (32) | Operand after modification |
| out_wr_en | output | 1 | Write the result back |
| out_z | output | 1 | New zero flag |
| out_z_en | output | 1 | Update the zero flag |

## Verification
The bench builds the unit with its defaults: a 32-bit operand, an 8-bit memory width and a 6-bit bit number. The 6-bit bit number allows values from 32 to 63 in register mode and from 8 to 63 in byte mode, so both wrap paths are exercised. It is not simply truncated.

Every bit position is swept with the change operation in both modes. Results are issued back to back and also separated by idle cycles, which exercises the hold behaviour.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
    typedef enum logic [1:0] {
        BOP_TEST = 2'd0,
        BOP_SET  = 2'd1,
        BOP_FLIP = 2'd2,
        BOP_CLR  = 2'd3
    } bop_e;
endpackage

// File: rtl/bitop_index.sv
module bitop_index #(
    parameter int REG_W   = 32,
    parameter int MEM_W   = 8,
    parameter int BITNO_W = 6,
    localparam int IDX_W  = $clog2(REG_W)
) (
    input  logic [BITNO_W-1:0] bitno,
    input  logic               mem_mode,
    output logic [IDX_W-1:0]   idx
);
    localparam logic [BITNO_W-1:0] REG_MOD = BITNO_W'(REG_W);
    localparam logic [BITNO_W-1:0] MEM_MOD = BITNO_W'(MEM_W);

    logic [BITNO_W-1:0] reg_wrap;
    logic [BITNO_W-1:0] mem_wrap;

    always_comb begin
        reg_wrap = bitno % REG_MOD;
        mem_wrap = bitno % MEM_MOD;
        idx      = mem_mode ? IDX_W'(mem_wrap) : IDX_W'(reg_wrap);
    end
endmodule

// File: rtl/bitop_modify.sv
module bitop_modify import bitop_pkg::*; #(
    parameter int REG_W  = 32,
    localparam int IDX_W = $clog2(REG_W)
) (
    input  logic [REG_W-1:0] data_in,
    input  logic [IDX_W-1:0] idx,
    input  bop_e             op,
    output logic [REG_W-1:0] data_out,
    output logic             old_bit
);
    assign old_bit = data_in[idx];

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        always_comb begin
            data_out[i] = data_in[i];
            if (idx == IDX_W'(i)) begin
                case (op)
                    BOP_SET:  data_out[i] = 1'b1;
                    BOP_CLR:  data_out[i] = 1'b0;
                    BOP_FLIP: data_out[i] = ~data_in[i];
                    default:  data_out[i] = data_in[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit import bitop_pkg::*; #(
    parameter int REG_W   = 32,
    parameter int MEM_W   = 8,
    parameter int BITNO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_op,
    input  logic               in_mem,
    input  logic [BITNO_W-1:0] in_bitno,
    input  logic [REG_W-1:0]   in_data,
    output logic               out_valid,
    output logic [REG_W-1:0]   out_data,
    output logic               out_wr_en,
    output logic               out_z,
    output logic               out_z_en
);
    localparam int IDX_W = $clog2(REG_W);

    typedef struct packed {
        logic             valid;
        logic             wr_en;
        logic             z_en;
        logic             z;
        logic [REG_W-1:0] data;
    } state_t;

    state_t           st_d, st_q;
    bop_e             op_sel;
    logic [IDX_W-1:0] bit_idx;
    logic [REG_W-1:0] mod_data;
    logic             old_bit;

    assign op_sel = bop_e'(in_op);

    bitop_index #(.REG_W(REG_W), .MEM_W(MEM_W), .BITNO_W(BITNO_W)) u_index (
        .bitno    (in_bitno),
        .mem_mode (in_mem),
        .idx      (bit_idx)
    );

    bitop_modify #(.REG_W(REG_W)) u_modify (
        .data_in  (in_data),
        .idx      (bit_idx),
        .op       (op_sel),
        .data_out (mod_data),
        .old_bit  (old_bit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.z_en  = in_valid;
        st_d.wr_en = in_valid && (op_sel != BOP_TEST);
        if (in_valid) begin
            st_d.z    = ~old_bit;
            st_d.data = mod_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
    assign out_wr_en = st_q.wr_en;
    assign out_z     = st_q.z;
    assign out_z_en  = st_q.z_en;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int REG_W   = 32,
    parameter int BITNO_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         in_op,
    input logic               in_mem,
    input logic [BITNO_W-1:0] in_bitno,
    input logic [REG_W-1:0]   in_data,
    input logic               out_valid,
    input logic [REG_W-1:0]   out_data,
    input logic               out_wr_en,
    input logic               out_z,
    input logic               out_z_en
);
    localparam int IDX_W = $clog2(REG_W);

    p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_test_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd0) |=> (!out_wr_en && out_data == $past(in_data)));
    p_write_ops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 2'd0) |=> out_wr_en);
    p_flag_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_z_en == out_valid);
    p_one_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($countones(out_data ^ $past(in_data)) <= 1));
    p_mem_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mem) |=> (out_data[REG_W-1:8] == $past(in_data[REG_W-1:8])));
    p_zflag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mem) |=> (out_z == !$past(in_data[in_bitno[IDX_W-1:0]])));
    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mem && in_op == 2'd1) |=> out_data[$past(in_bitno[IDX_W-1:0])]);
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mem && in_op == 2'd3) |=> !out_data[$past(in_bitno[IDX_W-1:0])]);
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_z)));
endmodule

bind bitop_unit bitop_unit_chk #(.REG_W(REG_W), .BITNO_W(BITNO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_mem    (in_mem),
    .in_bitno  (in_bitno),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_wr_en (out_wr_en),
    .out_z     (out_z),
    .out_z_en  (out_z_en)
);

// File: tb/tb_bitop_unit.sv
`timescale 1ns/1ps
module tb_bitop_unit;
    localparam int REG_W   = 32;
    localparam int MEM_W   = 8;
    localparam int BITNO_W = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [1:0]         in_op = '0;
    logic               in_mem = 1'b0;
    logic [BITNO_W-1:0] in_bitno = '0;
    logic [REG_W-1:0]   in_data = '0;
    logic               out_valid;
    logic [REG_W-1:0]   out_data;
    logic               out_wr_en;
    logic               out_z;
    logic               out_z_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit armed  = 1'b0;

    typedef struct {
        logic [REG_W-1:0] data;
        logic             wr;
        logic             z;
        string            tag;
    } exp_t;
    exp_t sbq[$];

    always #2 clk = ~clk;

    bitop_unit #(.REG_W(REG_W), .MEM_W(MEM_W), .BITNO_W(BITNO_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_mem(in_mem), .in_bitno(in_bitno), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_wr_en(out_wr_en),
        .out_z(out_z), .out_z_en(out_z_en)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic mem, input int bn,
                         input logic [REG_W-1:0] d, input string tag);
        exp_t e;
        int   idx;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_mem = mem;
        in_bitno = BITNO_W'(bn); in_data = d;
        idx    = mem ? (bn % MEM_W) : (bn % REG_W);
        e.data = d;
        e.z    = ~d[idx];
        e.wr   = (op != 2'd0);
        case (op)
            2'd1: e.data[idx] = 1'b1;
            2'd2: e.data[idx] = ~d[idx];
            2'd3: e.data[idx] = 1'b0;
            default: ;
        endcase
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    exp_t last;
    bit   have_last = 1'b0;

    always @(negedge clk) begin
        if (armed) begin
            if (out_valid) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R2 unexpected result", 64'(out_valid), 64'd0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(out_data == e.data, {e.tag, " data"}, 64'(out_data), 64'(e.data));
                    check(out_z == e.z, {"R3 ", e.tag, " z"}, 64'(out_z), 64'(e.z));
                    check(out_wr_en == e.wr, {"R11 ", e.tag, " wr_en"}, 64'(out_wr_en), 64'(e.wr));
                    check(out_z_en, "R11 z_en on result", 64'(out_z_en), 64'd1);
                    last = e;
                    have_last = 1'b1;
                end
            end else begin
                check(!out_wr_en && !out_z_en, "R11 enables idle",
                      64'({out_wr_en, out_z_en}), 64'd0);
                if (have_last)
                    check(out_data == last.data && out_z == last.z, "R12 hold",
                          64'({out_z, out_data}), 64'({last.z, last.data}));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_data == 0 && out_wr_en == 0 && out_z == 0 && out_z_en == 0,
              "R1 reset state", 64'({out_valid, out_wr_en, out_z, out_z_en}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && out_data == 0, "R1 after reset", 64'(out_data), 64'd0);
        armed = 1'b1;

        drive(2'd0, 1'b0, 3,  32'h0000_7B65, "R7 test bit3");
        drive(2'd1, 1'b0, 3,  32'h0000_7B65, "R4 set bit3");
        drive(2'd2, 1'b0, 0,  32'h0000_7B65, "R6 change bit0");
        drive(2'd3, 1'b0, 31, 32'h8000_0001, "R5 clear bit31");
        idle(2);
        drive(2'd1, 1'b0, 37, 32'h0000_0000, "R8 set wraps 37");
        drive(2'd3, 1'b0, 63, 32'hFFFF_FFFF, "R8 clear wraps 63");
        drive(2'd0, 1'b0, 32, 32'h0000_0001, "R8 test wraps 32");
        idle(1);
        drive(2'd1, 1'b1, 13, 32'hFFFF_0000, "R9 mem set wraps 13");
        drive(2'd3, 1'b1, 7,  32'hFFFF_FFFF, "R9 mem clear bit7");
        drive(2'd2, 1'b1, 15, 32'h0000_8000, "R9 mem change wraps 15");
        drive(2'd0, 1'b1, 9,  32'h0000_0002, "R9 mem test wraps 9");
        idle(3);
        for (int b = 0; b < REG_W; b++)
            drive(2'd2, 1'b0, b, 32'hA5C3_0F96, "R10 reg sweep");
        for (int b = 0; b < 16; b++)
            drive(2'd2, 1'b1, b, 32'h5A3C_F069, "R10 mem sweep");
        idle(4);
        check(sbq.size() == 0, "R2 all results seen", 64'(sbq.size()), 64'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule